// File: doc/BRIEF.md
# Contact Smart Card Power Sequencer

This block brings a contact smart card up and down in a fixed, timed order on command from a host controller. The host asks for a session by pulling an active-low command line from high to low and ends it by returning the line high. The block drives four card-side enables: supply, I/O, clock and card reset. It spaces each step by a programmable number of clock cycles. Card presence and three digital fault flags (over-current, over-temperature, supply drop) are watched throughout. Any fault or a card removal during a session forces an emergency shutdown in the safe order. It also pulls an active-low interrupt line low so the host learns of the event.

Host inputs pass through a latch that freezes while chip-select is low. In that state the host-side interrupt driver is released, which is modelled as an output-enable dropping low. A power-down request parks the block in a low-power state, but only when no session is open. A lockout timer blocks activation for a fixed time after reset and again after power-down ends.

Top module: `card_seq_top`

## Requirements
- R1: While reset is held and right after it, vcc_en, io_en, clk_en and card_rst are 0, pd_active is 0, and irq_n equals card_present with irq_oe equal to cs_n.
- R2: For LOCKOUT_CYC cycles after reset, a high-to-low transition of cmd_n starts no session.
- R3: A session starts only on a 1-to-0 transition of the latched cmd_n. A cmd_n held at 0 starts nothing. vcc_en rises on the second clock edge after cmd_n falls.
- R4: Activation raises vcc_en, then io_en ACT_STEP cycles later, then clk_en another ACT_STEP cycles later. The session enters its active phase a further ACT_STEP cycles later. card_rst stays 0 throughout activation.
- R5: In the active phase, card_rst copies the latched host_rst one cycle later.
- R6: When the latched cmd_n returns to 1, card_rst drops on the next edge. clk_en, io_en and vcc_en then drop in that order, each DEACT_STEP cycles after the previous one.
- R7: During a session, a 1 on flt_ocp, flt_otp or flt_uv, or a 0 on card_present, drops card_rst and pulls irq_n to 0 on the very next edge. The rest of the shutdown runs with the R6 spacing.
- R8: A fault or removal stays latched on irq_n after the cause has gone. It is cleared one edge after the latched cmd_n is 1. If a fault and a cmd_n release arrive together, the fault timing governs the shutdown and irq_n returns to 1 one cycle later.
- R9: A falling cmd_n edge while irq_n is 0 (for example, no card present) starts no session.
- R10: pwr_down is ignored while a session is open. With no session open and latched cmd_n at 1, pd_active rises two edges after the request, and no session can start while it is 1.
- R11: Leaving power-down restarts the LOCKOUT_CYC activation lockout.
- R12: While cs_n is 0, changes on cmd_n, host_rst and pwr_down have no effect, and irq_oe is 0. The held values are taken in once cs_n returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; low freezes host inputs |
| cmd_n | input | 1 | Host session request, active low, edge sensitive |
| host_rst | input | 1 | Host value for the card reset line |
| pwr_down | input | 1 | Host power-down request |
| card_present | input | 1 | 1 when a card sits in the slot |
| flt_ocp | input | 1 | Over-current flag |
| flt_otp | input | 1 | Over-temperature flag |
| flt_uv | input | 1 | Supply drop flag |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card I/O drive enable (0 = receive) |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset line |
| irq_n | output | 1 | Interrupt value, low on absent card or latched fault |
| irq_oe | output | 1 | Interrupt driver enable, 0 = high impedance |
| pd_active | output | 1 | Block is in power-down |

## Verification
A fault flag and the host's release of cmd_n can land in the same cycle, and they start the same shutdown by two routes. The fault reaches the sequencer directly, while cmd_n passes through the host latch. The bench raises flt_ocp and cmd_n on one falling clock edge during an active session. It checks that card_rst drops one cycle later, as for a fault, and that irq_n is low for exactly one cycle before the acknowledge clears it. It also checks that vcc_en goes off after exactly one shutdown sequence.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_A_VCC = 3'd1,
        S_A_IO  = 3'd2,
        S_A_CLK = 3'd3,
        S_ON    = 3'd4,
        S_D_RST = 3'd5,
        S_D_CLK = 3'd6,
        S_D_IO  = 3'd7
    } seq_state_t;

    typedef struct packed {
        logic vcc;
        logic io;
        logic clk;
        logic rst;
    } card_pins_t;

    typedef struct packed {
        logic cmd_n;
        logic rstin;
        logic pwrdn;
    } host_in_t;

    localparam host_in_t HOST_RESET = '{cmd_n: 1'b1, rstin: 1'b0, pwrdn: 1'b0};

    function automatic logic in_session(input seq_state_t s);
        return (s == S_A_VCC) || (s == S_A_IO) || (s == S_A_CLK) || (s == S_ON);
    endfunction

    function automatic logic card_trouble(input logic present, input logic ocp,
                                          input logic otp, input logic uv);
        return !present || ocp || otp || uv;
    endfunction

endpackage

// File: rtl/card_host_latch.sv
module card_host_latch
    import card_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  host_in_t raw,
    output host_in_t held
);
    always_ff @(posedge clk) begin
        if (rst)       held <= HOST_RESET;
        else if (cs_n) held <= raw;
    end
endmodule

// File: rtl/card_power_gate.sv
module card_power_gate #(
    parameter int LOCKOUT_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    input  logic idle_ok,
    output logic pd_active,
    output logic ready
);
    localparam int LW = $clog2(LOCKOUT_CYC + 1);
    localparam logic [LW-1:0] LOCK_LD = LW'(LOCKOUT_CYC);

    logic [LW-1:0] lock_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_active <= 1'b0;
        end else if (pd_active) begin
            if (!pd_req) pd_active <= 1'b0;
        end else if (pd_req && idle_ok) begin
            pd_active <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pd_active) lock_cnt <= LOCK_LD;
        else if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
    end

    assign ready = (lock_cnt == '0) && !pd_active;
endmodule

// File: rtl/card_fault_irq.sv
module card_fault_irq
    import card_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_t state,
    input  logic       trouble,
    input  logic       present,
    input  logic       ack,
    output logic       irq_n
);
    logic latched;
    logic set_now;

    assign set_now = in_session(state) && trouble;

    always_ff @(posedge clk) begin
        if (rst)          latched <= 1'b0;
        else if (set_now) latched <= 1'b1;
        else if (ack)     latched <= 1'b0;
    end

    assign irq_n = present && !latched;
endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
    import card_seq_pkg::*;
#(
    parameter int ACT_STEP   = 16,
    parameter int DEACT_STEP = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  host_in_t   h,
    input  logic       ready,
    input  logic       irq_ok,
    input  logic       trouble,
    output seq_state_t state,
    output card_pins_t pins
);
    localparam int STEP_MAX = (ACT_STEP > DEACT_STEP) ? ACT_STEP : DEACT_STEP;
    localparam int CW = $clog2(STEP_MAX + 1);
    localparam logic [CW-1:0] ACT_LD = CW'(ACT_STEP - 1);
    localparam logic [CW-1:0] DEA_LD = CW'(DEACT_STEP - 1);

    logic [CW-1:0] cnt;
    logic          prev_cmd_n;
    logic          fall, start, stop;

    assign fall  = prev_cmd_n && !h.cmd_n;
    assign start = (state == S_IDLE) && fall && ready && irq_ok;
    assign stop  = in_session(state) && (h.cmd_n || trouble);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            pins       <= '0;
            cnt        <= '0;
            prev_cmd_n <= 1'b1;
        end else begin
            prev_cmd_n <= h.cmd_n;
            if (state == S_IDLE) begin
                if (start) begin
                    state    <= S_A_VCC;
                    pins.vcc <= 1'b1;
                    cnt      <= ACT_LD;
                end
            end else if (stop) begin
                state    <= S_D_RST;
                pins.rst <= 1'b0;
                cnt      <= DEA_LD;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                unique case (state)
                    S_A_VCC: begin
                        state   <= S_A_IO;
                        pins.io <= 1'b1;
                        cnt     <= ACT_LD;
                    end
                    S_A_IO: begin
                        state    <= S_A_CLK;
                        pins.clk <= 1'b1;
                        cnt      <= ACT_LD;
                    end
                    S_A_CLK: state <= S_ON;
                    S_ON:    pins.rst <= h.rstin;
                    S_D_RST: begin
                        state    <= S_D_CLK;
                        pins.clk <= 1'b0;
                        cnt      <= DEA_LD;
                    end
                    S_D_CLK: begin
                        state   <= S_D_IO;
                        pins.io <= 1'b0;
                        cnt     <= DEA_LD;
                    end
                    S_D_IO: begin
                        state    <= S_IDLE;
                        pins.vcc <= 1'b0;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/card_seq_top.sv
module card_seq_top
    import card_seq_pkg::*;
#(
    parameter int LOCKOUT_CYC = 2000,
    parameter int ACT_STEP    = 16,
    parameter int DEACT_STEP  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic cmd_n,
    input  logic host_rst,
    input  logic pwr_down,
    input  logic card_present,
    input  logic flt_ocp,
    input  logic flt_otp,
    input  logic flt_uv,
    output logic vcc_en,
    output logic io_en,
    output logic clk_en,
    output logic card_rst,
    output logic irq_n,
    output logic irq_oe,
    output logic pd_active
);
    host_in_t   raw, held;
    seq_state_t state;
    card_pins_t pins;
    logic       ready, trouble, irq_val;

    assign raw     = '{cmd_n: cmd_n, rstin: host_rst, pwrdn: pwr_down};
    assign trouble = card_trouble(card_present, flt_ocp, flt_otp, flt_uv);

    card_host_latch u_latch (
        .clk(clk), .rst(rst), .cs_n(cs_n), .raw(raw), .held(held)
    );

    card_power_gate #(.LOCKOUT_CYC(LOCKOUT_CYC)) u_pwr (
        .clk(clk), .rst(rst), .pd_req(held.pwrdn),
        .idle_ok((state == S_IDLE) && held.cmd_n),
        .pd_active(pd_active), .ready(ready)
    );

    card_fault_irq u_irq (
        .clk(clk), .rst(rst), .state(state), .trouble(trouble),
        .present(card_present), .ack(held.cmd_n), .irq_n(irq_val)
    );

    card_seq_fsm #(.ACT_STEP(ACT_STEP), .DEACT_STEP(DEACT_STEP)) u_fsm (
        .clk(clk), .rst(rst), .h(held), .ready(ready), .irq_ok(irq_val),
        .trouble(trouble), .state(state), .pins(pins)
    );

    assign vcc_en   = pins.vcc;
    assign io_en    = pins.io;
    assign clk_en   = pins.clk;
    assign card_rst = pins.rst;
    assign irq_n    = irq_val;
    assign irq_oe   = cs_n;
endmodule

// File: rtl/card_seq_checker.sv
module card_seq_checker (
    input logic clk,
    input logic rst,
    input logic card_present,
    input logic flt_ocp,
    input logic flt_otp,
    input logic flt_uv,
    input logic vcc_en,
    input logic io_en,
    input logic clk_en,
    input logic card_rst,
    input logic irq_n,
    input logic pd_active
);
    AST_IO_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst)
        io_en |-> vcc_en); // R4
    AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> io_en); // R6
    AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (rst)
        card_rst |-> clk_en); // R4
    AST_FAULT_DROPS_RST: assert property (@(posedge clk) disable iff (rst)
        (card_rst && (flt_ocp || flt_otp || flt_uv || !card_present)) |=> !card_rst); // R7
    AST_REMOVAL_IRQ: assert property (@(posedge clk) disable iff (rst)
        (card_rst && !card_present) |=> !irq_n); // R7
    AST_PD_CARD_OFF: assert property (@(posedge clk) disable iff (rst)
        pd_active |-> !vcc_en); // R10
endmodule

bind card_seq_top card_seq_checker u_chk (
    .clk(clk), .rst(rst), .card_present(card_present), .flt_ocp(flt_ocp),
    .flt_otp(flt_otp), .flt_uv(flt_uv), .vcc_en(vcc_en), .io_en(io_en),
    .clk_en(clk_en), .card_rst(card_rst), .irq_n(irq_n), .pd_active(pd_active)
);

// File: tb/card_seq_top_tb.sv
module card_seq_top_tb;
    localparam int LOCK = 200;
    localparam int ACT  = 4;
    localparam int DEA  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, cmd_n = 1'b1, host_rst = 1'b1, pwr_down = 1'b0;
    logic card_present = 1'b1, flt_ocp = 1'b0, flt_otp = 1'b0, flt_uv = 1'b0;
    logic vcc_en, io_en, clk_en, card_rst, irq_n, irq_oe, pd_active;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    card_seq_top #(.LOCKOUT_CYC(LOCK), .ACT_STEP(ACT), .DEACT_STEP(DEA)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_n(cmd_n), .host_rst(host_rst),
        .pwr_down(pwr_down), .card_present(card_present), .flt_ocp(flt_ocp),
        .flt_otp(flt_otp), .flt_uv(flt_uv), .vcc_en(vcc_en), .io_en(io_en),
        .clk_en(clk_en), .card_rst(card_rst), .irq_n(irq_n), .irq_oe(irq_oe),
        .pd_active(pd_active)
    );

    // fields: present, ocp, otp, uv, expect_abort
    localparam logic [4:0] VEC [5] = '{
        5'b1_0_0_0_0,
        5'b0_0_0_0_1,
        5'b1_1_0_0_1,
        5'b1_0_1_0_1,
        5'b1_0_0_1_1
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // open a session and bring it to the active phase with card_rst high
    task automatic open_session(input bit check);
        cmd_n = 1'b0;
        wn(1);
        if (check) chk("R3", "vcc one edge after fall", vcc_en, 1'b0);
        wn(1);
        if (check) begin
            chk("R3", "vcc two edges after fall", vcc_en, 1'b1);
            chk("R4", "io not yet", io_en, 1'b0);
        end
        wn(ACT - 1);
        if (check) chk("R4", "io just before step", io_en, 1'b0);
        wn(1);
        if (check) begin
            chk("R4", "io after step", io_en, 1'b1);
            chk("R4", "clk not yet", clk_en, 1'b0);
        end
        wn(ACT);
        if (check) begin
            chk("R4", "clk after step", clk_en, 1'b1);
            chk("R4", "rst low in activation", card_rst, 1'b0);
        end
        wn(ACT);
        if (check) chk("R5", "rst waits one cycle in active", card_rst, 1'b0);
        wn(1);
        if (check) chk("R5", "rst follows host", card_rst, 1'b1);
    endtask

    initial begin
        wn(3);
        chk("R1", "vcc in reset", vcc_en, 1'b0);
        chk("R1", "rst in reset", card_rst, 1'b0);
        chk("R1", "irq in reset", irq_n, 1'b1);
        rst = 1'b0;
        wn(1);
        chk("R1", "io after reset", io_en, 1'b0);
        chk("R1", "clk after reset", clk_en, 1'b0);
        chk("R1", "pd after reset", pd_active, 1'b0);
        chk("R1", "irq_oe after reset", irq_oe, 1'b1);

        // R2: edge inside lockout ignored; R3: level low afterwards starts nothing
        wn(4);
        cmd_n = 1'b0;
        wn(LOCK + 50);
        chk("R2", "no start from lockout edge", vcc_en, 1'b0);
        chk("R3", "held low level starts nothing", vcc_en, 1'b0);
        cmd_n = 1'b1;
        wn(3);
        open_session(1'b1);

        // R5: host reset tracking
        host_rst = 1'b0;
        wn(1);
        chk("R5", "rst one edge after host change", card_rst, 1'b1);
        wn(1);
        chk("R5", "rst two edges after host change", card_rst, 1'b0);
        host_rst = 1'b1;
        wn(3);

        // R10: power-down ignored in session
        pwr_down = 1'b1;
        wn(5);
        chk("R10", "pd ignored in session", pd_active, 1'b0);
        chk("R10", "session kept", vcc_en, 1'b1);
        pwr_down = 1'b0;
        wn(3);

        // R6: host deactivation
        cmd_n = 1'b1;
        wn(1);
        chk("R6", "rst still high", card_rst, 1'b1);
        wn(1);
        chk("R6", "rst low", card_rst, 1'b0);
        chk("R6", "clk still on", clk_en, 1'b1);
        wn(DEA);
        chk("R6", "clk off", clk_en, 1'b0);
        chk("R6", "io still on", io_en, 1'b1);
        wn(DEA);
        chk("R6", "io off", io_en, 1'b0);
        chk("R6", "vcc still on", vcc_en, 1'b1);
        wn(DEA);
        chk("R6", "vcc off", vcc_en, 1'b0);
        wn(3);

        // R7 / R8: table of fault patterns during a session
        for (int i = 0; i < 5; i++) begin
            logic ab;
            ab = VEC[i][0];
            open_session(1'b0);
            card_present = VEC[i][4];
            flt_ocp = VEC[i][3];
            flt_otp = VEC[i][2];
            flt_uv  = VEC[i][1];
            wn(1);
            chk("R7", $sformatf("irq vec%0d", i), irq_n, !ab);
            chk("R7", $sformatf("rst vec%0d", i), card_rst, !ab);
            wn(3 * DEA);
            chk("R7", $sformatf("vcc vec%0d", i), vcc_en, !ab);
            card_present = 1'b1;
            flt_ocp = 1'b0;
            flt_otp = 1'b0;
            flt_uv  = 1'b0;
            wn(2);
            chk("R8", $sformatf("latched vec%0d", i), irq_n, !ab);
            cmd_n = 1'b1;
            wn(1);
            chk("R8", $sformatf("not cleared yet vec%0d", i), irq_n, !ab);
            wn(1 + 3 * DEA + 2);
            chk("R8", $sformatf("cleared vec%0d", i), irq_n, 1'b1);
            chk("R6", $sformatf("idle vec%0d", i), vcc_en, 1'b0);
        end

        // R8: fault and host release in the same cycle
        open_session(1'b0);
        cmd_n = 1'b1;
        flt_ocp = 1'b1;
        wn(1);
        chk("R8", "same-cycle rst low", card_rst, 1'b0);
        chk("R8", "same-cycle irq low", irq_n, 1'b0);
        flt_ocp = 1'b0;
        wn(1);
        chk("R8", "same-cycle irq cleared", irq_n, 1'b1);
        wn(3 * DEA - 2);
        chk("R8", "same-cycle vcc still on", vcc_en, 1'b1);
        wn(1);
        chk("R8", "same-cycle vcc off", vcc_en, 1'b0);
        wn(3);

        // R9: no card, no activation
        card_present = 1'b0;
        wn(1);
        chk("R9", "irq low without card", irq_n, 1'b0);
        cmd_n = 1'b0;
        wn(10);
        chk("R9", "no start without card", vcc_en, 1'b0);
        cmd_n = 1'b1;
        card_present = 1'b1;
        wn(3);

        // R10 / R11: power-down when idle
        pwr_down = 1'b1;
        wn(1);
        chk("R10", "pd one edge", pd_active, 1'b0);
        wn(1);
        chk("R10", "pd two edges", pd_active, 1'b1);
        cmd_n = 1'b0;
        wn(10);
        chk("R10", "no start in pd", vcc_en, 1'b0);
        cmd_n = 1'b1;
        pwr_down = 1'b0;
        wn(3);
        chk("R11", "pd left", pd_active, 1'b0);
        cmd_n = 1'b0;
        wn(10);
        chk("R11", "lockout after pd", vcc_en, 1'b0);
        cmd_n = 1'b1;
        wn(LOCK + 20);
        cmd_n = 1'b0;
        wn(2);
        chk("R11", "start after lockout", vcc_en, 1'b1);
        cmd_n = 1'b1;
        wn(3 * DEA + 6);

        // R12: chip select holds inputs
        cs_n = 1'b0;
        wn(1);
        chk("R12", "irq_oe low", irq_oe, 1'b0);
        cmd_n = 1'b0;
        wn(10);
        chk("R12", "frozen cmd", vcc_en, 1'b0);
        cs_n = 1'b1;
        wn(1);
        chk("R12", "irq_oe back", irq_oe, 1'b1);
        wn(1);
        chk("R12", "held edge taken", vcc_en, 1'b1);
        cmd_n = 1'b1;
        wn(3 * DEA + 6);
        chk("R6", "final idle", vcc_en, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule